// File: doc/BRIEF.md
# Embedded-Sync 4:2:2 Byte Stream Formatter

This block turns a 4:2:2 pixel stream, with one luma value and one alternating chroma value per pixel, into a single 8-bit stream. Timing is carried inside the stream as four-byte start and end markers. It runs on the byte clock, which is twice the pixel rate. Each `line_start` pulse starts one line. The line holds a start-of-active marker, then `cfg_act_len` pixels written as Cb, Y, Cr, Y bytes, then an end-of-active marker. Neutral blanking codes follow until the next pulse. The block asks for a new pixel pair by raising `pix_next` on the cycle in which it takes the luma byte of the current pair.

Each marker carries three flags. F gives the field, V gives vertical blanking and H separates start from end. Protection bits are added to the flags. The flags can be captured at the start marker or at the end marker. Video bytes are clipped so that the two codes reserved for markers never appear in picture data. Lines that carry VBI data can use a 7-bit plus odd parity coding instead of clipping. On blanked lines, marker pairs can be dropped, except on the first few blanked lines of each run, so that vertical sync can still be found.

Top module: `itu656_formatter`

## Requirements
- R1: After reset, `dout` is 0x10 and `pix_next` is 0.
- R2: Let a `line_start` pulse be seen at clock edge t. From edge t+1, `dout` presents one byte per cycle: 4 start-marker bytes, then 2×`cfg_act_len` active bytes, then 4 end-marker bytes. Active byte k is chroma (`c_i`) for even k and luma (`y_i`) for odd k, so the order is Cb, Y, Cr, Y. `pix_next` is high exactly on the cycles in which an odd active byte of a data line is taken.
- R3: A marker that is not dropped is the bytes 0xFF, 0x00, 0x00, then a status byte. The status byte is, from MSB to LSB: 1, F, V, H, V^H, F^H, F^V, F^V^H.
- R4: For FVH = 000 through 111, the status byte is 0x80, 0x9D, 0xAB, 0xB6, 0xC7, 0xDA, 0xEC, 0xF1. H is 0 in the start marker and 1 in the end marker. F is `field_i`.
- R5: On video lines, any active byte below 0x01 is sent as 0x01 and any byte above 0xFE is sent as 0xFE.
- R6: After the end marker, until the next `line_start`, bytes alternate 0x80, 0x10, 0x80, … with 0x80 first.
- R7: A line that has `vblank_i`=1 and `vbi_act_i`=0 when it starts is blanked. Its markers carry V=1, its active bytes alternate 0x80/0x10, and `pix_next` stays low.
- R8: A line that has `vbi_act_i`=1 carries data like a video line, and its markers carry V=0 even while `vblank_i`=1.
- R9: When `cfg_vbi_par`=1, each active byte d on a line with `vbi_act_i`=1 is sent as {d[7:1], p}, where p makes the byte's count of ones odd. Video lines are still clipped.
- R10: With `cfg_flag_eav`=0, F and V are captured at `line_start` and used by both markers of that line. With `cfg_flag_eav`=1, they are captured when the end marker begins and are used until the next end marker.
- R11: With `cfg_supp`=1, a blanked line that follows at least KEEP_LINES (default 2) blanked lines sends both of its markers as 0x80, 0x10, 0x80, 0x10. The first KEEP_LINES blanked lines of each run keep their markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock (twice the pixel rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that begins a line |
| field_i | input | 1 | Field: 0 first, 1 second |
| vblank_i | input | 1 | Vertical blanking interval |
| vbi_act_i | input | 1 | Current line carries VBI data |
| y_i | input | 8 | Luma of the current pixel pair |
| c_i | input | 8 | Chroma of the current pixel pair (Cb then Cr) |
| cfg_act_len | input | CNT_W | Active pixels per line |
| cfg_flag_eav | input | 1 | Capture flags at end marker instead of start |
| cfg_supp | input | 1 | Drop marker pairs on blanked lines |
| cfg_vbi_par | input | 1 | 7-bit plus odd parity coding on VBI lines |
| dout | output | 8 | Formatted byte stream |
| pix_next | output | 1 | Pixel pair taken; present the next one |

## Verification
Two pairs of functions can act on the same line. First, with end-marker flag capture selected, a change of field on `field_i` can arrive while the start marker is still being sent. The bench changes the field during the start marker and checks two things: the start marker keeps the previous capture, and the end marker of the same line shows the new field. Second, the pair-dropping decision is made on the same edge as the blanked-line run count is updated. Three blanked lines in a row are therefore sent after an active line. The first two must keep their markers and the third must lose both markers together. A following VBI line must get its markers back with V=0.

// File: rtl/itu656_fmt_pkg.sv
`timescale 1ns/1ps
package itu656_fmt_pkg;

   typedef enum logic [1:0] {
      SEG_IDLE = 2'd0,
      SEG_SAV  = 2'd1,
      SEG_ACT  = 2'd2,
      SEG_EAV  = 2'd3
   } seg_t;

   localparam logic [7:0] FILL_LUMA   = 8'h10;
   localparam logic [7:0] FILL_CHROMA = 8'h80;
   localparam logic [7:0] MARK_HI     = 8'hFF;
   localparam logic [7:0] MARK_LO     = 8'h00;
   localparam logic [7:0] CLIP_MIN    = 8'h01;
   localparam logic [7:0] CLIP_MAX    = 8'hFE;

   // status word with protection bits
   function automatic logic [7:0] mark_status(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   // neutral code, chroma on even slots and luma on odd slots
   function automatic logic [7:0] neutral(input logic odd_slot);
      return odd_slot ? FILL_LUMA : FILL_CHROMA;
   endfunction

   function automatic logic [7:0] clip_video(input logic [7:0] d);
      if (d < CLIP_MIN) return CLIP_MIN;
      if (d > CLIP_MAX) return CLIP_MAX;
      return d;
   endfunction

   // keep 7 MSBs and add an LSB that makes the byte's parity odd
   function automatic logic [7:0] odd_par7(input logic [7:0] d);
      return {d[7:1], ~(^d[7:1])};
   endfunction

endpackage

// File: rtl/itu656_fmt_seq.sv
`timescale 1ns/1ps
module itu656_fmt_seq
   import itu656_fmt_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic [CNT_W-1:0] act_len,
   output seg_t             seg,
   output logic [CNT_W:0]   cnt,
   output logic             eav_enter
);

   localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};
   localparam logic [CNT_W:0] HDR3 = (CNT_W + 1)'(3);

   logic [CNT_W:0] act_last;
   logic           no_act;
   logic           sav_done;
   logic           act_done;

   assign act_last = {act_len, 1'b0} - ONE;
   assign no_act   = (act_len == '0);
   assign sav_done = (seg == SEG_SAV) && (cnt == HDR3);
   assign act_done = (seg == SEG_ACT) && (cnt == act_last);

   assign eav_enter = !line_start && (act_done || (sav_done && no_act));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg <= SEG_IDLE;
         cnt <= '0;
      end else if (line_start) begin
         seg <= SEG_SAV;
         cnt <= '0;
      end else begin
         unique case (seg)
            SEG_SAV: begin
               if (sav_done) begin
                  seg <= no_act ? SEG_EAV : SEG_ACT;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            SEG_ACT: begin
               if (act_done) begin
                  seg <= SEG_EAV;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            SEG_EAV: begin
               if (cnt == HDR3) begin
                  seg <= SEG_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            default: cnt <= cnt + ONE;
         endcase
      end
   end

endmodule

// File: rtl/itu656_fmt_flags.sv
`timescale 1ns/1ps
module itu656_fmt_flags #(
   parameter int KEEP_LINES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_start,
   input  logic eav_enter,
   input  logic field_i,
   input  logic vblank_i,
   input  logic vbi_act_i,
   input  logic cfg_flag_eav,
   input  logic cfg_supp,
   output logic f_q,
   output logic v_q,
   output logic line_blank,
   output logic line_vbi,
   output logic supp_q
);

   localparam int BLK_W = $clog2(KEEP_LINES + 1);
   localparam logic [BLK_W-1:0] KEEP_V = BLK_W'(KEEP_LINES);
   localparam logic [BLK_W-1:0] B_ONE  = BLK_W'(1);

   logic             v_eff;
   logic             grab;
   logic [BLK_W-1:0] blk_run;

   assign v_eff = vblank_i & ~vbi_act_i;
   assign grab  = cfg_flag_eav ? eav_enter : line_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_q <= 1'b0;
         v_q <= 1'b0;
      end else if (grab) begin
         f_q <= field_i;
         v_q <= v_eff;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_blank <= 1'b0;
         line_vbi   <= 1'b0;
         supp_q     <= 1'b0;
         blk_run    <= '0;
      end else if (line_start) begin
         line_blank <= v_eff;
         line_vbi   <= vbi_act_i;
         supp_q     <= cfg_supp & v_eff & (blk_run >= KEEP_V);
         if (!v_eff)
            blk_run <= '0;
         else if (blk_run < KEEP_V)
            blk_run <= blk_run + B_ONE;
      end
   end

endmodule

// File: rtl/itu656_fmt_byte.sv
`timescale 1ns/1ps
module itu656_fmt_byte
   import itu656_fmt_pkg::*;
#(
   parameter bit VBI_PAR_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  seg_t       seg,
   input  logic [1:0] slot,
   input  logic       f_q,
   input  logic       v_q,
   input  logic       line_blank,
   input  logic       line_vbi,
   input  logic       supp_q,
   input  logic       cfg_vbi_par,
   input  logic [7:0] y_i,
   input  logic [7:0] c_i,
   output logic [7:0] dout,
   output logic       pix_next
);

   logic       use_par;
   logic [7:0] raw;
   logic [7:0] coded;
   logic [7:0] hdr;
   logic [7:0] nxt;

   generate
      if (VBI_PAR_EN) begin : g_par
         assign use_par = cfg_vbi_par & line_vbi;
      end else begin : g_nopar
         assign use_par = 1'b0 & cfg_vbi_par;
      end
   endgenerate

   assign raw   = slot[0] ? y_i : c_i;
   assign coded = use_par ? odd_par7(raw) : clip_video(raw);

   always_comb begin
      unique case (slot)
         2'd0:    hdr = MARK_HI;
         2'd3:    hdr = mark_status(f_q, v_q, seg == SEG_EAV);
         default: hdr = MARK_LO;
      endcase
   end

   always_comb begin
      unique case (seg)
         SEG_SAV, SEG_EAV: nxt = supp_q ? neutral(slot[0]) : hdr;
         SEG_ACT:          nxt = line_blank ? neutral(slot[0]) : coded;
         default:          nxt = neutral(slot[0]);
      endcase
   end

   assign pix_next = (seg == SEG_ACT) && slot[0] && !line_blank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout <= FILL_LUMA;
      else        dout <= nxt;
   end

endmodule

// File: rtl/itu656_formatter.sv
`timescale 1ns/1ps
module itu656_formatter
   import itu656_fmt_pkg::*;
#(
   parameter int CNT_W      = 11,
   parameter int KEEP_LINES = 2,
   parameter bit VBI_PAR_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic             field_i,
   input  logic             vblank_i,
   input  logic             vbi_act_i,
   input  logic [7:0]       y_i,
   input  logic [7:0]       c_i,
   input  logic [CNT_W-1:0] cfg_act_len,
   input  logic             cfg_flag_eav,
   input  logic             cfg_supp,
   input  logic             cfg_vbi_par,
   output logic [7:0]       dout,
   output logic             pix_next
);

   generate
      if (CNT_W < 2)       $error("CNT_W must be at least 2");
      if (KEEP_LINES < 1)  $error("KEEP_LINES must be at least 1");
   endgenerate

   seg_t           seg;
   logic [CNT_W:0] cnt;
   logic           eav_enter;
   logic           f_q, v_q, line_blank, line_vbi, supp_q;

   itu656_fmt_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .act_len    (cfg_act_len),
      .seg        (seg),
      .cnt        (cnt),
      .eav_enter  (eav_enter)
   );

   itu656_fmt_flags #(.KEEP_LINES(KEEP_LINES)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_start   (line_start),
      .eav_enter    (eav_enter),
      .field_i      (field_i),
      .vblank_i     (vblank_i),
      .vbi_act_i    (vbi_act_i),
      .cfg_flag_eav (cfg_flag_eav),
      .cfg_supp     (cfg_supp),
      .f_q          (f_q),
      .v_q          (v_q),
      .line_blank   (line_blank),
      .line_vbi     (line_vbi),
      .supp_q       (supp_q)
   );

   itu656_fmt_byte #(.VBI_PAR_EN(VBI_PAR_EN)) u_byte (
      .clk         (clk),
      .rst_n       (rst_n),
      .seg         (seg),
      .slot        (cnt[1:0]),
      .f_q         (f_q),
      .v_q         (v_q),
      .line_blank  (line_blank),
      .line_vbi    (line_vbi),
      .supp_q      (supp_q),
      .cfg_vbi_par (cfg_vbi_par),
      .y_i         (y_i),
      .c_i         (c_i),
      .dout        (dout),
      .pix_next    (pix_next)
   );

endmodule

// File: rtl/itu656_formatter_chk.sv
`timescale 1ns/1ps
module itu656_formatter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] dout,
   input logic       pix_next
);

   // R3
   mark_lo_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout == 8'hFF) |=> (dout == 8'h00));

   // R5
   zero_only_in_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dout == 8'h00) |-> ($past(dout) == 8'hFF || $past(dout) == 8'h00));

   // R4
   status_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dout, 3) == 8'hFF && $past(dout, 2) == 8'h00 && $past(dout, 1) == 8'h00)
      |-> (dout[7] && dout[3] == (dout[5] ^ dout[4]) && dout[2] == (dout[6] ^ dout[4])
           && dout[1] == (dout[6] ^ dout[5]) && dout[0] == (dout[6] ^ dout[5] ^ dout[4])));

   // R2
   pix_pair_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_next |=> !pix_next);

endmodule

bind itu656_formatter itu656_formatter_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dout     (dout),
   .pix_next (pix_next)
);

// File: tb/tb_itu656_formatter.sv
`timescale 1ns/1ps
module tb_itu656_formatter;

   localparam int N    = 8;
   localparam int HB   = 6;
   localparam int KEEP = 2;
   localparam int TOT  = 8 + 2 * N + HB;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_start = 1'b0;
   logic        field_i = 1'b0, vblank_i = 1'b0, vbi_act_i = 1'b0;
   logic [7:0]  y_i = 8'h00, c_i = 8'h00;
   logic [10:0] cfg_act_len = 11'(N);
   logic        cfg_flag_eav = 1'b0, cfg_supp = 1'b0, cfg_vbi_par = 1'b0;
   logic [7:0]  dout;
   logic        pix_next;

   int n_run = 0, n_fail = 0;
   logic mf = 1'b0, mv = 1'b0;
   int   mb = 0;
   logic [7:0] cap  [0:TOT-1];
   logic [7:0] expv [0:TOT-1];
   logic [7:0] stat_tab [0:7] = '{8'h80, 8'h9D, 8'hAB, 8'hB6, 8'hC7, 8'hDA, 8'hEC, 8'hF1};

   always #2.5 clk = ~clk;

   itu656_formatter dut (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_i(field_i),
      .vblank_i(vblank_i), .vbi_act_i(vbi_act_i), .y_i(y_i), .c_i(c_i),
      .cfg_act_len(cfg_act_len), .cfg_flag_eav(cfg_flag_eav), .cfg_supp(cfg_supp),
      .cfg_vbi_par(cfg_vbi_par), .dout(dout), .pix_next(pix_next)
   );

   function automatic logic [7:0] yf(int seed, int p);
      return (p == 0) ? 8'hFF : 8'((seed * 7 + p * 53) & 255);
   endfunction
   function automatic logic [7:0] cf(int seed, int p);
      return (p == 1) ? 8'h00 : 8'((64 + seed + p * 29) & 255);
   endfunction
   function automatic logic [7:0] fillb(int i);
      return (i % 2 == 1) ? 8'h10 : 8'h80;
   endfunction
   function automatic logic [7:0] conv(logic [7:0] d, logic par);
      if (par) return {d[7:1], ~(^d[7:1])};
      if (d == 8'h00) return 8'h01;
      if (d == 8'hFF) return 8'hFE;
      return d;
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cmp_seg(input int a, input int b, input string req);
      int bad = -1;
      for (int i = a; i < b; i++)
         if (bad < 0 && cap[i] !== expv[i]) bad = i;
      if (bad < 0) check(1'b1, req, 0, 0);
      else         check(1'b0, $sformatf("%s byte %0d", req, bad), cap[bad], expv[bad]);
   endtask

   task automatic run_line(input logic fld, input logic vb, input logic vbi,
                           input logic chg, input logic nfld, input int seed,
                           input string tag);
      logic ve, sup;
      int p, npix;
      ve = vb & ~vbi;
      if (!cfg_flag_eav) begin mf = fld; mv = ve; end
      sup = cfg_supp && ve && (mb >= KEEP);
      mb  = ve ? ((mb < KEEP) ? mb + 1 : mb) : 0;
      for (int i = 0; i < 4; i++)
         expv[i] = sup ? fillb(i) : (i == 0 ? 8'hFF : (i == 3 ? stat_tab[{mf, mv, 1'b0}] : 8'h00));
      for (int k = 0; k < 2 * N; k++)
         expv[4 + k] = ve ? fillb(k)
                          : conv((k % 2 == 1) ? yf(seed, k / 2) : cf(seed, k / 2), vbi && cfg_vbi_par);
      if (cfg_flag_eav) begin mf = chg ? nfld : fld; mv = ve; end
      for (int i = 0; i < 4; i++)
         expv[4 + 2 * N + i] = sup ? fillb(i)
            : (i == 0 ? 8'hFF : (i == 3 ? stat_tab[{mf, mv, 1'b1}] : 8'h00));
      for (int j = 0; j < HB; j++) expv[8 + 2 * N + j] = fillb(j);

      @(negedge clk);
      field_i = fld; vblank_i = vb; vbi_act_i = vbi; line_start = 1'b1;
      p = 0; npix = 0;
      for (int n = 0; n <= TOT; n++) begin
         @(negedge clk);
         line_start = 1'b0;
         if (n == 2 && chg) field_i = nfld;
         y_i = yf(seed, p); c_i = cf(seed, p);
         if (n >= 1) cap[n - 1] = dout;
         if (pix_next) begin p++; npix++; end
      end
      cmp_seg(0, 4, {tag, " start marker"});
      cmp_seg(4, 4 + 2 * N, {tag, " active bytes"});
      cmp_seg(4 + 2 * N, 8 + 2 * N, {tag, " end marker"});
      cmp_seg(8 + 2 * N, TOT, {tag, " R6 blanking fill"});
      check(npix == (ve ? 0 : N), {tag, " R2 pix_next count"}, npix, ve ? 0 : N);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(dout == 8'h10, "R1 reset dout", dout, 8'h10);
      check(pix_next == 1'b0, "R1 reset pix_next", pix_next, 0);
   endtask

   task automatic t_video();
      run_line(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R2 R3 R4 R5 field1");
      run_line(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2, "R4 R5 field2");
   endtask

   task automatic t_blanked();
      run_line(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3, "R7 R4 blanked");
   endtask

   task automatic t_vbi();
      run_line(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4, "R8 vbi clipped");
      cfg_vbi_par = 1'b1;
      run_line(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5, "R9 vbi parity");
      run_line(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6, "R9 video clipped");
      cfg_vbi_par = 1'b0;
   endtask

   task automatic t_flag_eav();
      cfg_flag_eav = 1'b1;
      run_line(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7, "R10 eav capture a");
      run_line(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8, "R10 eav capture b");
      cfg_flag_eav = 1'b0;
      run_line(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9, "R10 sav capture");
   endtask

   task automatic t_supp();
      cfg_supp = 1'b1;
      run_line(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10, "R11 active");
      run_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11, "R11 blank kept 1");
      run_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12, "R11 blank kept 2");
      run_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 13, "R11 blank dropped");
      run_line(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 14, "R11 R8 vbi kept");
      cfg_supp = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_video();
      t_blanked();
      t_vbi();
      t_flag_eav();
      t_supp();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule